// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit owns the program counter of a small single-issue 32-bit RISC core. Every clock it looks at the instruction word being executed, together with the two source register values read for it. It then chooses the address of the next instruction, which is one of the following:

- the sequential successor;
- a PC-relative branch target;
- a region-relative direct jump target;
- an address taken from a register.

For the linking jumps it also presents a link value and the index of the register that receives it. The register file consumes these with a plain write strobe.

There is no streaming data path, so every pin is a plain control or data signal with no handshake. The instruction and operands must be stable before each rising edge, and the PC register moves on every edge. Fetch, the register file, exceptions and delay slots belong to neighbouring blocks.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high `rst` loads `pc` with the parameter `BOOT_ADDR` (default 0x0040_0000) at the next rising edge.
- R2: An instruction whose opcode (bits 31:26) is 8 or above makes the next `pc` equal `pc + 4`.
- R3: Opcode 000100 branches when `rs_val == rt_val`, and opcode 000101 branches when they differ. A taken branch loads `pc + 4 + (sign-extended bits 15:0 << 2)`; otherwise the next PC is `pc + 4`.
- R4: Opcode 000110 branches when signed `rs_val <= 0`, and opcode 000111 branches when signed `rs_val > 0`. Both branch only when bits 20:16 are 00000; any other value there gives `pc + 4`.
- R5: Under opcode 000001, bits 20:16 = 00000 branches when signed `rs_val < 0`, and 00001 branches when signed `rs_val >= 0`. Every other value of bits 20:16 gives `pc + 4`.
- R6: Opcodes 000010 and 000011 load `{(pc+4)[31:28], bits 25:0, 2'b00}`.
- R7: Opcode 000000 with function (bits 5:0) 001000 or 001001 loads `rs_val` with bits 1:0 cleared. `misalign` is high during that cycle exactly when `rs_val[1:0]` is nonzero, and it is low for every other instruction.
- R8: Opcode 000011 drives `link_we` high with `link_idx` = 31. Opcode 000000 with function 001001 drives `link_we` high with `link_idx` = bits 15:11. In both cases `link_data` = `pc + 4`, and `link_we` is low for all other instructions.
- R9: Opcode 000000 with any function other than 001000 or 001001 gives `pc + 4` and no link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Link write strobe for linking jumps |
| link_idx | output | 5 | Destination register of the link value |
| link_data | output | 32 | Link value, the address after the current one |
| misalign | output | 1 | Register jump target had nonzero low bits |

## Verification
The hardest case to reach is the direct jump target, whose upper four bits are inherited from the incremented PC. Those bits stay zero while the PC remains near the boot address. To reach it, the stimulus first performs a register jump into a high region (0xA000_0010) and then issues a direct jump from there. The result must keep the high nibble 0xA. Each table vector starts from reset, so expected targets are fixed numbers relative to the boot address.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    K_SEQ  = 2'd0,
    K_BR   = 2'd1,
    K_JDIR = 2'd2,
    K_JREG = 2'd3
  } flow_kind_t;

  typedef enum logic [2:0] {
    C_EQ  = 3'd0,
    C_NE  = 3'd1,
    C_LEZ = 3'd2,
    C_GTZ = 3'd3,
    C_LTZ = 3'd4,
    C_GEZ = 3'd5
  } br_cond_t;

  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_REGIMM  = 6'b000001;
  localparam logic [5:0] OP_JUMP    = 6'b000010;
  localparam logic [5:0] OP_JLINK   = 6'b000011;
  localparam logic [5:0] OP_BEQ     = 6'b000100;
  localparam logic [5:0] OP_BNE     = 6'b000101;
  localparam logic [5:0] OP_BLEZ    = 6'b000110;
  localparam logic [5:0] OP_BGTZ    = 6'b000111;
  localparam logic [5:0] FN_JREG    = 6'b001000;
  localparam logic [5:0] FN_JRLINK  = 6'b001001;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int LINK_RA = 31
) (
  input  logic [5:0]       opcode,
  input  logic [4:0]       sel_fld,
  input  logic [IDX_W-1:0] dst_fld,
  input  logic [5:0]       funct,
  output flow_kind_t       kind,
  output br_cond_t         cond,
  output logic             link,
  output logic [IDX_W-1:0] link_dst
);
  always_comb begin
    kind     = K_SEQ;
    cond     = C_EQ;
    link     = 1'b0;
    link_dst = IDX_W'(LINK_RA);
    unique case (opcode)
      OP_SPECIAL: begin
        if (funct == FN_JREG) kind = K_JREG;
        else if (funct == FN_JRLINK) begin
          kind     = K_JREG;
          link     = 1'b1;
          link_dst = dst_fld;
        end
      end
      OP_REGIMM: begin
        if (sel_fld == 5'b00000) begin
          kind = K_BR; cond = C_LTZ;
        end else if (sel_fld == 5'b00001) begin
          kind = K_BR; cond = C_GEZ;
        end
      end
      OP_JUMP:  kind = K_JDIR;
      OP_JLINK: begin
        kind = K_JDIR;
        link = 1'b1;
      end
      OP_BEQ: begin kind = K_BR; cond = C_EQ; end
      OP_BNE: begin kind = K_BR; cond = C_NE; end
      OP_BLEZ: if (sel_fld == 5'b00000) begin kind = K_BR; cond = C_LEZ; end
      OP_BGTZ: if (sel_fld == 5'b00000) begin kind = K_BR; cond = C_GTZ; end
      default: kind = K_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_cond_t        cond,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            take
);
  logic neg, zero, same;
  assign neg  = a[XLEN-1];
  assign zero = (a == '0);
  assign same = (a == b);

  always_comb begin
    unique case (cond)
      C_EQ:    take = same;
      C_NE:    take = !same;
      C_LEZ:   take = neg || zero;
      C_GTZ:   take = !neg && !zero;
      C_LTZ:   take = neg;
      C_GEZ:   take = !neg;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [TGT_W-1:0] field,
  output logic [XLEN-1:0]  pc_inc,
  output logic [XLEN-1:0]  br_dest,
  output logic [XLEN-1:0]  jmp_dest
);
  localparam int HI_W = XLEN - TGT_W - 2;
  localparam int EXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] off_bytes;

  assign pc_inc    = pc + XLEN'(4);
  assign off_bytes = {{EXT_W{field[OFF_W-1]}}, field[OFF_W-1:0], 2'b00};
  assign br_dest   = pc_inc + off_bytes;
  assign jmp_dest  = {pc_inc[XLEN-1 -: HI_W], field, 2'b00};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              IDX_W     = 5,
  parameter int              LINK_RA   = 31,
  parameter logic [XLEN-1:0] BOOT_ADDR = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      instr,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  pc,
  output logic             link_we,
  output logic [IDX_W-1:0] link_idx,
  output logic [XLEN-1:0]  link_data,
  output logic             misalign
);
  flow_kind_t      kind;
  br_cond_t        cond;
  logic            take;
  logic [XLEN-1:0] pc_inc, br_dest, jmp_dest, reg_dest, pc_nxt;

  npc_decode #(.IDX_W(IDX_W), .LINK_RA(LINK_RA)) u_dec (
    .opcode  (instr[31:26]),
    .sel_fld (instr[20:16]),
    .dst_fld (instr[15:11]),
    .funct   (instr[5:0]),
    .kind    (kind),
    .cond    (cond),
    .link    (link_we),
    .link_dst(link_idx)
  );

  npc_cond #(.XLEN(XLEN)) u_cmp (
    .cond(cond),
    .a   (rs_val),
    .b   (rt_val),
    .take(take)
  );

  npc_target #(.XLEN(XLEN)) u_tgt (
    .pc      (pc),
    .field   (instr[25:0]),
    .pc_inc  (pc_inc),
    .br_dest (br_dest),
    .jmp_dest(jmp_dest)
  );

  assign reg_dest  = {rs_val[XLEN-1:2], 2'b00};
  assign misalign  = (kind == K_JREG) && (rs_val[1:0] != 2'b00);
  assign link_data = pc_inc;

  always_comb begin
    unique case (kind)
      K_BR:    pc_nxt = take ? br_dest : pc_inc;
      K_JDIR:  pc_nxt = jmp_dest;
      K_JREG:  pc_nxt = reg_dest;
      default: pc_nxt = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= BOOT_ADDR;
    else     pc <= pc_nxt;
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter logic [31:0] BOOT_ADDR = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] pc,
  input logic        link_we,
  input logic [4:0]  link_idx,
  input logic [31:0] link_data,
  input logic        misalign
);
  logic rst_q = 1'b0;
  logic is_jreg;
  assign is_jreg = (instr[31:26] == 6'd0) && (instr[5:1] == 5'b00100);

  always @(posedge clk) begin
    // R1
    if (rst_q) boot_load_chk: assert (pc == BOOT_ADDR);
    rst_q <= rst;
  end

  // R2
  plain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:29] != 3'd0) |=> (pc == $past(pc) + 32'd4));

  // R7
  jreg_dest_chk: assert property (@(posedge clk) disable iff (rst)
    is_jreg |=> (pc == {$past(rs_val[31:2]), 2'b00}));

  // R7
  misalign_src_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (is_jreg && rs_val[1:0] != 2'b00));

  // R8
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_data == pc + 32'd4));

  // R8
  jal_ra_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'b000011) |-> (link_we && link_idx == 5'd31));

  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_q |-> (pc[1:0] == 2'b00));
endmodule

bind npc_unit npc_unit_chk #(.BOOT_ADDR(BOOT_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .instr    (instr),
  .rs_val   (rs_val),
  .pc       (pc),
  .link_we  (link_we),
  .link_idx (link_idx),
  .link_data(link_data),
  .misalign (misalign)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
  localparam logic [31:0] BOOT = 32'h0040_0000;
  localparam logic [31:0] NOP  = 32'h2000_0000;

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] rs;
    logic [31:0] rt;
    logic [31:0] nxt;
    logic        we;
    logic [4:0]  idx;
    logic        mis;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{32'h2000_0000, 32'h0,         32'h0, 32'h0040_0004, 1'b0, 5'd0,  1'b0}, // R2 addi
    '{32'h1000_0003, 32'h5,         32'h5, 32'h0040_0010, 1'b0, 5'd0,  1'b0}, // R3 beq taken
    '{32'h1000_0003, 32'h5,         32'h6, 32'h0040_0004, 1'b0, 5'd0,  1'b0}, // R3 beq not
    '{32'h1400_FFFF, 32'h1,         32'h2, 32'h0040_0000, 1'b0, 5'd0,  1'b0}, // R3 bne back
    '{32'h1800_0002, 32'h0,         32'h0, 32'h0040_000C, 1'b0, 5'd0,  1'b0}, // R4 blez 0
    '{32'h1800_0002, 32'h1,         32'h0, 32'h0040_0004, 1'b0, 5'd0,  1'b0}, // R4 blez +
    '{32'h1C00_0002, 32'h8000_0000, 32'h0, 32'h0040_0004, 1'b0, 5'd0,  1'b0}, // R4 bgtz neg
    '{32'h1C00_0002, 32'h7,         32'h0, 32'h0040_000C, 1'b0, 5'd0,  1'b0}, // R4 bgtz +
    '{32'h1C01_0002, 32'h7,         32'h0, 32'h0040_0004, 1'b0, 5'd0,  1'b0}, // R4 bad rt
    '{32'h0400_0010, 32'hFFFF_FFFF, 32'h0, 32'h0040_0044, 1'b0, 5'd0,  1'b0}, // R5 bltz
    '{32'h0400_0010, 32'h0,         32'h0, 32'h0040_0004, 1'b0, 5'd0,  1'b0}, // R5 bltz 0
    '{32'h0401_0010, 32'h0,         32'h0, 32'h0040_0044, 1'b0, 5'd0,  1'b0}, // R5 bgez 0
    '{32'h0401_0010, 32'h8000_0000, 32'h0, 32'h0040_0004, 1'b0, 5'd0,  1'b0}, // R5 bgez neg
    '{32'h0402_0010, 32'h0,         32'h0, 32'h0040_0004, 1'b0, 5'd0,  1'b0}, // R5 bad rt
    '{32'h0800_0100, 32'h0,         32'h0, 32'h0000_0400, 1'b0, 5'd0,  1'b0}, // R6 j
    '{32'h0C00_0010, 32'h0,         32'h0, 32'h0000_0040, 1'b1, 5'd31, 1'b0}, // R8 jal
    '{32'h0000_0008, 32'h0000_1234, 32'h0, 32'h0000_1234, 1'b0, 5'd0,  1'b0}, // R7 jr
    '{32'h0000_0008, 32'h0000_1237, 32'h0, 32'h0000_1234, 1'b0, 5'd0,  1'b1}, // R7 jr odd
    '{32'h0000_2809, 32'h0000_2000, 32'h0, 32'h0000_2000, 1'b1, 5'd5,  1'b0}, // R8 jalr
    '{32'h0000_0020, 32'h0000_2000, 32'h0, 32'h0040_0004, 1'b0, 5'd0,  1'b0}, // R9 add
    '{32'h0000_000A, 32'h0000_2000, 32'h0, 32'h0040_0004, 1'b0, 5'd0,  1'b0}  // R9 other fn
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = NOP, rs_val = '0, rt_val = '0;
  logic [31:0] pc, link_data;
  logic        link_we, misalign;
  logic [4:0]  link_idx;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .pc(pc), .link_we(link_we), .link_idx(link_idx), .link_data(link_data),
    .misalign(misalign)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic reset_pc();
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic step(input logic [31:0] i, input logic [31:0] a);
    instr = i; rs_val = a; rt_val = '0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset pc", pc, BOOT);
    check("R8 no link in reset idle", {31'd0, link_we}, 32'd0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      reset_pc();
      instr = VECS[k].ins; rs_val = VECS[k].rs; rt_val = VECS[k].rt;
      @(negedge clk);
      check($sformatf("R8 link_we vec%0d", k), {31'd0, link_we}, {31'd0, VECS[k].we});
      if (VECS[k].we) begin
        check($sformatf("R8 link_idx vec%0d", k), {27'd0, link_idx}, {27'd0, VECS[k].idx});
        check($sformatf("R8 link_data vec%0d", k), link_data, BOOT + 32'd4);
      end
      check($sformatf("R7 misalign vec%0d", k), {31'd0, misalign}, {31'd0, VECS[k].mis});
      @(posedge clk); #1;
      check($sformatf("next pc vec%0d", k), pc, VECS[k].nxt);
    end

    // R6: direct jump keeps the high nibble from the incremented PC
    reset_pc();
    step(32'h0000_0008, 32'hA000_0010);
    check("R7 jr into high region", pc, 32'hA000_0010);
    step(32'h0800_0100, 32'h0);
    check("R6 j keeps high nibble", pc, 32'hA000_0400);
    step(NOP, 32'h0);
    check("R2 sequential in high region", pc, 32'hA000_0404);
    instr = 32'h0C00_0010;
    @(negedge clk);
    check("R8 jal link_data in high region", link_data, 32'hA000_0408);
    @(posedge clk); #1;
    check("R6 jal keeps high nibble", pc, 32'hA000_0040);

    // R1: reset mid-run returns to boot address
    instr = NOP;
    reset_pc();
    check("R1 reset after run", pc, BOOT);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule